// File: doc/BRIEF.md
# ACPI Power-Management Event Controller

This block holds the fixed power-management event registers of an ACPI system: an event status register, an event enable register, a control register and a free-running power-management timer. All of them sit in a 64-byte I/O window whose base can be moved. Hardware event pulses set status bits. These sources are the timer's most significant bit toggling, a power-button request, a real-time-clock alarm and a global-lock release. Software clears a status bit by writing a one to it. A small general-purpose event pair carries a hotplug bit.

The block drives a level-sensitive SCI. SCI is high while any enabled fixed event is pending, or while the enabled hotplug general-purpose event is pending. It stays high until software clears the status bit or the enable bit. A separate APM command path turns ACPI mode on or off by writing command codes. Each APM command can also produce a one-cycle SMI pulse when configuration allows it. The window base and window enable come from configuration inputs. They take effect only when a commit strobe is given.

Top module: `acpi_pm_evt_ctrl`

## Requirements
- R1: After reset, all registers and the timer read zero, `sci_o` and `smi_o` are low, and the window is closed (`io_hit_o` low, read data zero).
- R2: On a `cfg_commit_i` cycle the block captures `cfg_base_i` ANDed with 0xFFC0, together with `cfg_win_en_i`. While the captured enable is set, an address whose bits 15:6 equal the captured base hits the window. Changes to the configuration inputs without a commit have no effect on decoding.
- R3: The event status register is at window offset 0x00. Its bits are timer bit 0, global lock bit 5, power button bit 8 and RTC bit 10. An event pulse sets its bit in the next cycle. Writing 1 to a bit clears it and writing 0 leaves it. When an event and a clear hit the same bit in the same cycle, the event wins.
- R4: The event enable register at offset 0x02 and the control register at offset 0x04 are plain 16-bit read/write registers. The ACPI-mode bit is control bit 0.
- R5: The timer advances by one on each `tmr_tick_i` cycle and reads zero-extended at offset 0x08. Each toggle of its most significant bit sets status bit 0.
- R6: `sci_o` is high whenever status AND enable has bit 0, 5, 8 or 10 set. Other bits never raise it.
- R7: The general-purpose status byte is at offset 0x0C and is write-1-to-clear. `hotplug_evt_i` sets its bit 1. The general-purpose enable byte at offset 0x0E is read/write. `sci_o` is also high when bit 1 is set in both bytes.
- R8: Once high, `sci_o` stays high until a window write clears the cause.
- R9: An APM write of 0xF1 sets control bit 0 in the next cycle and 0xF0 clears it. Any other code leaves it unchanged. On a tie with an I/O write to the control register, the APM command wins.
- R10: `smi_o` is high for exactly the one cycle after an APM write when `cfg_smi_en_i` is set, and is low otherwise.
- R11: Reads outside the window or at unmapped offsets return zero. Writes outside the window change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_commit_i | input | 1 | Capture window base and enable |
| cfg_base_i | input | 16 | Window base configuration value (low 6 bits ignored) |
| cfg_win_en_i | input | 1 | Window decode enable configuration bit |
| cfg_smi_en_i | input | 1 | Allow SMI after APM commands |
| io_addr_i | input | 16 | I/O address |
| io_wr_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 16 | I/O write data |
| io_rdata_o | output | 32 | Read data for `io_addr_i` (combinational) |
| io_hit_o | output | 1 | Address falls inside the open window |
| tmr_tick_i | input | 1 | Timer advance enable |
| pwrbtn_req_i | input | 1 | Power-button request pulse |
| rtc_evt_i | input | 1 | RTC alarm pulse |
| gbl_evt_i | input | 1 | Global-lock release pulse |
| hotplug_evt_i | input | 1 | Hotplug event pulse |
| apm_wr_i | input | 1 | APM command write strobe |
| apm_cmd_i | input | 8 | APM command code |
| sci_o | output | 1 | Level-sensitive SCI |
| smi_o | output | 1 | One-cycle SMI pulse |

## Verification
Read data and `io_hit_o` are combinational from the address. Writes, event pulses, ticks, commits and APM commands all land at the next rising edge. `sci_o` follows that same edge through logic only, and `smi_o` is high for exactly the one cycle after the APM strobe. The bench drives every input on the falling edge, holds it across one rising edge, and samples on the following falling edge. A read is checked one time unit after its address is applied. This places every check one cycle after its cause and keeps them clear of the active edge. The SCI hold, the same-cycle set-versus-clear race and the timer's MSB toggle are each checked at the exact cycle they resolve.

// File: rtl/acpi_pm_pkg.sv
// Shared constants and types for the ACPI power-management event controller.
package acpi_pm_pkg;

    // Window geometry: 64 bytes, so six offset bits.
    localparam int WIN_OFS_W = 6;

    // Register offsets inside the window.
    localparam logic [WIN_OFS_W-1:0] OFS_STS  = 6'h00;
    localparam logic [WIN_OFS_W-1:0] OFS_EN   = 6'h02;
    localparam logic [WIN_OFS_W-1:0] OFS_CTL  = 6'h04;
    localparam logic [WIN_OFS_W-1:0] OFS_TMR  = 6'h08;
    localparam logic [WIN_OFS_W-1:0] OFS_GSTS = 6'h0C;
    localparam logic [WIN_OFS_W-1:0] OFS_GEN  = 6'h0E;

    // Fixed-event bit positions (shared by status and enable).
    localparam int BIT_TMR = 0;
    localparam int BIT_GBL = 5;
    localparam int BIT_PWR = 8;
    localparam int BIT_RTC = 10;

    // General-purpose hotplug bit and control ACPI-mode bit.
    localparam int BIT_HP    = 1;
    localparam int BIT_SCIEN = 0;

    // Register widths.
    localparam int PM_REG_W = 16;
    localparam int GPE_W    = 8;

    // Fixed events that can raise SCI.
    localparam logic [PM_REG_W-1:0] SCI_MASK =
        PM_REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_RTC));

    // APM command codes.
    localparam logic [7:0] APM_ACPI_ON  = 8'hF1;
    localparam logic [7:0] APM_ACPI_OFF = 8'hF0;

    // Register selected by the window decoder.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STS,
        SEL_EN,
        SEL_CTL,
        SEL_TMR,
        SEL_GSTS,
        SEL_GEN
    } reg_sel_e;

endpackage

// File: rtl/acpi_pm_win.sv
// Relocatable I/O window decoder.
// Captures the base (aligned to the window size) and the window enable
// on a commit strobe. Produces the hit flag and the selected register.
// Assumes a naturally aligned power-of-two window.
module acpi_pm_win
    import acpi_pm_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              win_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic              win_en_o,
    output reg_sel_e          sel_o
);

    localparam logic [ADDR_W-1:0] BASE_MASK = ~ADDR_W'((1 << WIN_OFS_W) - 1);

    logic [ADDR_W-1:0] base_q;
    logic              en_q;
    logic [WIN_OFS_W-1:0] ofs;

    // Latch the masked base and the enable only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= 1'b0;
        end else if (commit_i) begin
            base_q <= base_i & BASE_MASK;
            en_q   <= win_en_i;
        end
    end

    // Compare the aligned address against the captured base.
    always_comb begin
        hit_o = en_q && ((addr_i & BASE_MASK) == base_q);
        ofs   = addr_i[WIN_OFS_W-1:0];
    end

    // Map the offset to a register select; unmapped offsets select nothing.
    always_comb begin
        sel_o = SEL_NONE;
        if (hit_o) begin
            case (ofs)
                OFS_STS:  sel_o = SEL_STS;
                OFS_EN:   sel_o = SEL_EN;
                OFS_CTL:  sel_o = SEL_CTL;
                OFS_TMR:  sel_o = SEL_TMR;
                OFS_GSTS: sel_o = SEL_GSTS;
                OFS_GEN:  sel_o = SEL_GEN;
                default:  sel_o = SEL_NONE;
            endcase
        end
    end

    assign win_en_o = en_q;

endmodule

// File: rtl/acpi_pm_tmr.sv
// Free-running power-management timer.
// Counts on each tick enable and flags the cycle in which its most
// significant bit toggles. Assumes the tick is synchronous to clk.
module acpi_pm_tmr #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [TMR_W-1:0] cnt_o,
    output logic             msb_flip_o
);

    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] cnt_nxt;

    // Next count value when a tick is present.
    always_comb begin
        cnt_nxt    = cnt_q + TMR_W'(1);
        msb_flip_o = tick_i && (cnt_nxt[TMR_W-1] != cnt_q[TMR_W-1]);
    end

    // Advance the counter on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_nxt;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/acpi_pm_regs.sv
// Event status, enable, control and general-purpose event registers.
// Status bits are set by event pulses and cleared by writing one, and a
// set takes priority over a clear in the same cycle. APM commands
// override I/O writes to the ACPI-mode control bit.
module acpi_pm_regs
    import acpi_pm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  reg_sel_e            sel_i,
    input  logic [PM_REG_W-1:0] wdata_i,
    input  logic                tmr_flip_i,
    input  logic                gbl_evt_i,
    input  logic                pwr_evt_i,
    input  logic                rtc_evt_i,
    input  logic                hp_evt_i,
    input  logic                apm_wr_i,
    input  logic [7:0]          apm_cmd_i,
    output logic [PM_REG_W-1:0] sts_o,
    output logic [PM_REG_W-1:0] en_o,
    output logic [PM_REG_W-1:0] ctl_o,
    output logic [GPE_W-1:0]    gsts_o,
    output logic [GPE_W-1:0]    gen_o
);

    logic [PM_REG_W-1:0] set_vec;
    logic [PM_REG_W-1:0] clr_vec;
    logic [GPE_W-1:0]    gset_vec;
    logic [GPE_W-1:0]    gclr_vec;
    logic [PM_REG_W-1:0] en_q;
    logic [PM_REG_W-1:0] ctl_q;
    logic [PM_REG_W-1:0] ctl_nxt;
    logic [GPE_W-1:0]    gen_q;

    // Collect event sets and write-one clears for both status registers.
    always_comb begin
        set_vec          = '0;
        set_vec[BIT_TMR] = tmr_flip_i;
        set_vec[BIT_GBL] = gbl_evt_i;
        set_vec[BIT_PWR] = pwr_evt_i;
        set_vec[BIT_RTC] = rtc_evt_i;
        clr_vec          = (wr_i && sel_i == SEL_STS) ? wdata_i : '0;
        gset_vec         = '0;
        gset_vec[BIT_HP] = hp_evt_i;
        gclr_vec         = (wr_i && sel_i == SEL_GSTS) ? wdata_i[GPE_W-1:0] : '0;
    end

    // One sticky cell per status bit: set wins over clear.
    for (genvar i = 0; i < PM_REG_W; i++) begin : g_sts
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_vec[i]) bit_q <= 1'b1;
            else if (clr_vec[i]) bit_q <= 1'b0;
        end
        assign sts_o[i] = bit_q;
    end

    // Same sticky cell per general-purpose status bit.
    for (genvar j = 0; j < GPE_W; j++) begin : g_gsts
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)           bit_q <= 1'b0;
            else if (gset_vec[j]) bit_q <= 1'b1;
            else if (gclr_vec[j]) bit_q <= 1'b0;
        end
        assign gsts_o[j] = bit_q;
    end

    // Control next value: I/O write first, APM command last so it wins.
    always_comb begin
        ctl_nxt = ctl_q;
        if (wr_i && sel_i == SEL_CTL) begin
            ctl_nxt = wdata_i;
        end
        if (apm_wr_i && apm_cmd_i == APM_ACPI_ON) begin
            ctl_nxt[BIT_SCIEN] = 1'b1;
        end else if (apm_wr_i && apm_cmd_i == APM_ACPI_OFF) begin
            ctl_nxt[BIT_SCIEN] = 1'b0;
        end
    end

    // Plain read/write registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            ctl_q <= '0;
            gen_q <= '0;
        end else begin
            ctl_q <= ctl_nxt;
            if (wr_i && sel_i == SEL_EN)  en_q  <= wdata_i;
            if (wr_i && sel_i == SEL_GEN) gen_q <= wdata_i[GPE_W-1:0];
        end
    end

    assign en_o  = en_q;
    assign ctl_o = ctl_q;
    assign gen_o = gen_q;

endmodule

// File: rtl/acpi_pm_sci.sv
// SCI level generator.
// Purely combinational: ORs the enabled fixed events in the SCI mask with
// the enabled hotplug general-purpose event. Assumes registered inputs.
module acpi_pm_sci
    import acpi_pm_pkg::*;
(
    input  logic [PM_REG_W-1:0] sts_i,
    input  logic [PM_REG_W-1:0] en_i,
    input  logic                hp_sts_i,
    input  logic                hp_en_i,
    output logic                sci_o
);

    // Evaluate the interrupt level from pending and enabled sources.
    always_comb begin
        sci_o = (|(sts_i & en_i & SCI_MASK)) || (hp_sts_i && hp_en_i);
    end

endmodule

// File: rtl/acpi_pm_evt_ctrl.sv
// ACPI power-management event controller, top level.
// Ties the window decoder, the timer, the register file and the SCI
// generator together, muxes read data and registers the SMI pulse.
// Assumes single-cycle I/O writes and a combinational read path.
module acpi_pm_evt_ctrl
    import acpi_pm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TMR_W  = 24,
    parameter int RD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_commit_i,
    input  logic [ADDR_W-1:0] cfg_base_i,
    input  logic              cfg_win_en_i,
    input  logic              cfg_smi_en_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic              io_wr_i,
    input  logic [PM_REG_W-1:0] io_wdata_i,
    output logic [RD_W-1:0]   io_rdata_o,
    output logic              io_hit_o,
    input  logic              tmr_tick_i,
    input  logic              pwrbtn_req_i,
    input  logic              rtc_evt_i,
    input  logic              gbl_evt_i,
    input  logic              hotplug_evt_i,
    input  logic              apm_wr_i,
    input  logic [7:0]        apm_cmd_i,
    output logic              sci_o,
    output logic              smi_o
);

    reg_sel_e            sel;
    logic                win_en_q;
    logic [TMR_W-1:0]    tmr_cnt;
    logic                tmr_flip;
    logic [PM_REG_W-1:0] sts;
    logic [PM_REG_W-1:0] en;
    logic [PM_REG_W-1:0] ctl_q;
    logic [GPE_W-1:0]    gsts;
    logic [GPE_W-1:0]    gen;
    logic                smi_q;

    acpi_pm_win #(
        .ADDR_W (ADDR_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (cfg_commit_i),
        .base_i   (cfg_base_i),
        .win_en_i (cfg_win_en_i),
        .addr_i   (io_addr_i),
        .hit_o    (io_hit_o),
        .win_en_o (win_en_q),
        .sel_o    (sel)
    );

    acpi_pm_tmr #(
        .TMR_W (TMR_W)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tmr_tick_i),
        .cnt_o      (tmr_cnt),
        .msb_flip_o (tmr_flip)
    );

    acpi_pm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (io_wr_i),
        .sel_i      (sel),
        .wdata_i    (io_wdata_i),
        .tmr_flip_i (tmr_flip),
        .gbl_evt_i  (gbl_evt_i),
        .pwr_evt_i  (pwrbtn_req_i),
        .rtc_evt_i  (rtc_evt_i),
        .hp_evt_i   (hotplug_evt_i),
        .apm_wr_i   (apm_wr_i),
        .apm_cmd_i  (apm_cmd_i),
        .sts_o      (sts),
        .en_o       (en),
        .ctl_o      (ctl_q),
        .gsts_o     (gsts),
        .gen_o      (gen)
    );

    acpi_pm_sci u_sci (
        .sts_i    (sts),
        .en_i     (en),
        .hp_sts_i (gsts[BIT_HP]),
        .hp_en_i  (gen[BIT_HP]),
        .sci_o    (sci_o)
    );

    // Read-data mux; zero for misses and unmapped offsets.
    always_comb begin
        case (sel)
            SEL_STS:  io_rdata_o = RD_W'(sts);
            SEL_EN:   io_rdata_o = RD_W'(en);
            SEL_CTL:  io_rdata_o = RD_W'(ctl_q);
            SEL_TMR:  io_rdata_o = RD_W'(tmr_cnt);
            SEL_GSTS: io_rdata_o = RD_W'(gsts);
            SEL_GEN:  io_rdata_o = RD_W'(gen);
            default:  io_rdata_o = '0;
        endcase
    end

    // One-cycle SMI pulse after an APM command when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) smi_q <= 1'b0;
        else        smi_q <= apm_wr_i && cfg_smi_en_i;
    end

    assign smi_o = smi_q;

endmodule

// File: rtl/acpi_pm_chk.sv
// Assertion checker for the ACPI power-management event controller.
// Bound to the top module; observes ports and a few internal states.
module acpi_pm_chk #(
    parameter int TMR_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             apm_wr_i,
    input logic [7:0]       apm_cmd_i,
    input logic             cfg_smi_en_i,
    input logic             smi_o,
    input logic             sci_o,
    input logic             io_wr_i,
    input logic             io_hit_o,
    input logic             win_en,
    input logic             sci_en,
    input logic             tmr_tick_i,
    input logic [TMR_W-1:0] tmr_val
);

    // R10: an allowed APM command gives SMI in the next cycle.
    p_smi_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr_i && cfg_smi_en_i) |=> smi_o);

    // R10: no APM command, no SMI in the next cycle.
    p_smi_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !apm_wr_i |=> !smi_o);

    // R9: ACPI-on command sets the mode bit.
    p_apm_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr_i && apm_cmd_i == 8'hF1) |=> sci_en);

    // R9: ACPI-off command clears the mode bit.
    p_apm_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr_i && apm_cmd_i == 8'hF0) |=> !sci_en);

    // R2: a closed window never hits.
    p_closed_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> !io_hit_o);

    // R8: SCI can only fall through a window write.
    p_sci_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_o && !io_wr_i) |=> sci_o);

    // R5: the timer advances by one per tick.
    p_tmr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_tick_i |=> tmr_val == TMR_W'($past(tmr_val) + TMR_W'(1)));

    // R5: without a tick the timer holds.
    p_tmr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_tick_i |=> $stable(tmr_val));

endmodule

bind acpi_pm_evt_ctrl acpi_pm_chk #(
    .TMR_W (TMR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .apm_wr_i     (apm_wr_i),
    .apm_cmd_i    (apm_cmd_i),
    .cfg_smi_en_i (cfg_smi_en_i),
    .smi_o        (smi_o),
    .sci_o        (sci_o),
    .io_wr_i      (io_wr_i),
    .io_hit_o     (io_hit_o),
    .win_en       (win_en_q),
    .sci_en       (ctl_q[0]),
    .tmr_tick_i   (tmr_tick_i),
    .tmr_val      (tmr_cnt)
);

// File: tb/acpi_pm_evt_ctrl_bench.sv
// Self-checking bench for the ACPI power-management event controller.
module acpi_pm_evt_ctrl_bench;

    localparam int TMR_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_commit_i = 1'b0;
    logic [15:0] cfg_base_i = '0;
    logic        cfg_win_en_i = 1'b0;
    logic        cfg_smi_en_i = 1'b0;
    logic [15:0] io_addr_i = '0;
    logic        io_wr_i = 1'b0;
    logic [15:0] io_wdata_i = '0;
    logic [31:0] io_rdata_o;
    logic        io_hit_o;
    logic        tmr_tick_i = 1'b0;
    logic        pwrbtn_req_i = 1'b0;
    logic        rtc_evt_i = 1'b0;
    logic        gbl_evt_i = 1'b0;
    logic        hotplug_evt_i = 1'b0;
    logic        apm_wr_i = 1'b0;
    logic [7:0]  apm_cmd_i = '0;
    logic        sci_o;
    logic        smi_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    acpi_pm_evt_ctrl #(
        .TMR_W (TMR_W)
    ) u_acpi_pm_evt_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_commit_i  (cfg_commit_i),
        .cfg_base_i    (cfg_base_i),
        .cfg_win_en_i  (cfg_win_en_i),
        .cfg_smi_en_i  (cfg_smi_en_i),
        .io_addr_i     (io_addr_i),
        .io_wr_i       (io_wr_i),
        .io_wdata_i    (io_wdata_i),
        .io_rdata_o    (io_rdata_o),
        .io_hit_o      (io_hit_o),
        .tmr_tick_i    (tmr_tick_i),
        .pwrbtn_req_i  (pwrbtn_req_i),
        .rtc_evt_i     (rtc_evt_i),
        .gbl_evt_i     (gbl_evt_i),
        .hotplug_evt_i (hotplug_evt_i),
        .apm_wr_i      (apm_wr_i),
        .apm_cmd_i     (apm_cmd_i),
        .sci_o         (sci_o),
        .smi_o         (smi_o)
    );

    // Stimulus vectors: write or read-and-compare inside the window at 0xB000.
    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 16'hB000, 16'h0000, 32'h0000_0000}, // R3 status idle
        '{1'b1, 16'hB002, 16'h0521, 32'h0},         // R4 enable write
        '{1'b0, 16'hB002, 16'h0000, 32'h0000_0521}, // R4 enable readback
        '{1'b1, 16'hB004, 16'h0001, 32'h0},         // R4 control write
        '{1'b0, 16'hB004, 16'h0000, 32'h0000_0001}, // R4 control readback
        '{1'b1, 16'hB004, 16'h0000, 32'h0},         // R4 control clear
        '{1'b0, 16'hB004, 16'h0000, 32'h0000_0000}, // R4 control readback
        '{1'b1, 16'hB00E, 16'h0002, 32'h0},         // R7 gpe enable write
        '{1'b0, 16'hB00E, 16'h0000, 32'h0000_0002}, // R7 gpe enable readback
        '{1'b0, 16'hB006, 16'h0000, 32'h0000_0000}, // R11 unmapped offset
        '{1'b0, 16'hB03C, 16'h0000, 32'h0000_0000}, // R11 unmapped offset
        '{1'b1, 16'hB000, 16'hFFFF, 32'h0},         // R3 clear on empty status
        '{1'b0, 16'hB000, 16'h0000, 32'h0000_0000}  // R3 status still empty
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr_i  = a;
        io_wdata_i = d;
        io_wr_i    = 1'b1;
        @(negedge clk);
        io_wr_i    = 1'b0;
    endtask

    task automatic io_read(input string tag, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk);
        io_addr_i = a;
        #1;
        check(tag, io_rdata_o, exp);
    endtask

    task automatic apm(input logic [7:0] c);
        @(negedge clk);
        apm_cmd_i = c;
        apm_wr_i  = 1'b1;
        @(negedge clk);
        apm_wr_i  = 1'b0;
    endtask

    task automatic commit(input logic [15:0] b, input logic en);
        @(negedge clk);
        cfg_base_i   = b;
        cfg_win_en_i = en;
        cfg_commit_i = 1'b1;
        @(negedge clk);
        cfg_commit_i = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        io_addr_i = 16'hB000;
        #1;
        check("R1 sci low", {31'b0, sci_o}, 32'h0);
        check("R1 smi low", {31'b0, smi_o}, 32'h0);
        check("R1 window closed", {31'b0, io_hit_o}, 32'h0);
        check("R1 read zero", io_rdata_o, 32'h0);

        // R2: open window at 0xB03F masked to 0xB000
        commit(16'hB03F, 1'b1);
        io_read("R1 timer zero", 16'hB008, 32'h0);
        check("R2 hit at base", {31'b0, io_hit_o}, 32'h1);
        io_read("R2 miss above", 16'hB040, 32'h0);
        check("R2 no hit above", {31'b0, io_hit_o}, 32'h0);

        // Vector table walk (R3, R4, R7, R11)
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) begin
                io_write(VECS[i].addr, VECS[i].data);
            end else begin
                io_read($sformatf("vector %0d (R3/R4/R7/R11)", i), VECS[i].addr, VECS[i].exp);
            end
        end

        // R11: write outside the window leaves enable alone
        io_write(16'hB042, 16'h0000);
        io_read("R11 outside write ignored", 16'hB002, 32'h0521);

        // R3/R6: power button sets bit 8 and raises SCI
        @(negedge clk); pwrbtn_req_i = 1'b1;
        @(negedge clk); pwrbtn_req_i = 1'b0;
        check("R6 sci on power button", {31'b0, sci_o}, 32'h1);
        io_read("R3 power status", 16'hB000, 32'h0100);
        // R8: level holds without writes
        repeat (4) @(negedge clk);
        check("R8 sci held", {31'b0, sci_o}, 32'h1);
        io_write(16'hB000, 16'h0100);
        check("R8 sci cleared by w1c", {31'b0, sci_o}, 32'h0);
        io_read("R3 w1c cleared", 16'hB000, 32'h0);

        // R3: set wins over same-cycle clear
        @(negedge clk);
        io_addr_i = 16'hB000; io_wdata_i = 16'h0100; io_wr_i = 1'b1; pwrbtn_req_i = 1'b1;
        @(negedge clk);
        io_wr_i = 1'b0; pwrbtn_req_i = 1'b0;
        io_read("R3 set beats clear", 16'hB000, 32'h0100);
        io_write(16'hB000, 16'h0100);

        // R6: masked RTC event leaves SCI low until enabled
        io_write(16'hB002, 16'h0000);
        @(negedge clk); rtc_evt_i = 1'b1;
        @(negedge clk); rtc_evt_i = 1'b0;
        check("R6 rtc masked", {31'b0, sci_o}, 32'h0);
        io_read("R3 rtc status", 16'hB000, 32'h0400);
        io_write(16'hB002, 16'h0400);
        check("R6 rtc enabled", {31'b0, sci_o}, 32'h1);
        io_write(16'hB000, 16'h0400);

        // R6: global lock, and a non-SCI enable bit never raises SCI
        io_write(16'hB002, 16'hFADE & ~16'h0521);
        @(negedge clk); gbl_evt_i = 1'b1;
        @(negedge clk); gbl_evt_i = 1'b0;
        check("R6 gbl masked by enable", {31'b0, sci_o}, 32'h0);
        io_write(16'hB002, 16'h0020);
        check("R6 gbl enabled", {31'b0, sci_o}, 32'h1);
        io_write(16'hB000, 16'h0020);
        check("R6 gbl cleared", {31'b0, sci_o}, 32'h0);

        // R7: hotplug general-purpose event (enable bit 1 still set)
        @(negedge clk); hotplug_evt_i = 1'b1;
        @(negedge clk); hotplug_evt_i = 1'b0;
        check("R7 hotplug sci", {31'b0, sci_o}, 32'h1);
        io_read("R7 gpe status", 16'hB00C, 32'h0002);
        io_write(16'hB00C, 16'h0002);
        check("R7 hotplug cleared", {31'b0, sci_o}, 32'h0);
        io_write(16'hB00E, 16'h0000);
        @(negedge clk); hotplug_evt_i = 1'b1;
        @(negedge clk); hotplug_evt_i = 1'b0;
        check("R7 hotplug masked", {31'b0, sci_o}, 32'h0);
        io_write(16'hB00C, 16'h00FF);

        // R5: timer counts ticks and MSB toggle sets status bit 0
        io_write(16'hB002, 16'h0001);
        @(negedge clk); tmr_tick_i = 1'b1;
        repeat (5) @(negedge clk);
        tmr_tick_i = 1'b0;
        io_read("R5 timer five", 16'hB008, 32'h5);
        check("R5 no toggle yet", {31'b0, sci_o}, 32'h0);
        @(negedge clk); tmr_tick_i = 1'b1;
        repeat (123) @(negedge clk);
        tmr_tick_i = 1'b0;
        io_read("R5 timer at msb", 16'hB008, 32'h80);
        io_read("R5 toggle status", 16'hB000, 32'h0001);
        check("R6 timer sci", {31'b0, sci_o}, 32'h1);
        io_write(16'hB000, 16'h0001);

        // R9: APM commands
        apm(8'hF1);
        io_read("R9 acpi on", 16'hB004, 32'h1);
        apm(8'h55);
        io_read("R9 other code ignored", 16'hB004, 32'h1);
        apm(8'hF0);
        io_read("R9 acpi off", 16'hB004, 32'h0);
        // R9: APM beats a same-cycle control write
        @(negedge clk);
        io_addr_i = 16'hB004; io_wdata_i = 16'h0000; io_wr_i = 1'b1;
        apm_cmd_i = 8'hF1; apm_wr_i = 1'b1;
        @(negedge clk);
        io_wr_i = 1'b0; apm_wr_i = 1'b0;
        io_read("R9 apm wins tie", 16'hB004, 32'h1);

        // R10: SMI pulse only when allowed
        check("R10 smi idle", {31'b0, smi_o}, 32'h0);
        cfg_smi_en_i = 1'b1;
        @(negedge clk); apm_cmd_i = 8'h10; apm_wr_i = 1'b1;
        @(negedge clk); apm_wr_i = 1'b0;
        check("R10 smi pulse", {31'b0, smi_o}, 32'h1);
        @(negedge clk);
        check("R10 smi one cycle", {31'b0, smi_o}, 32'h0);
        cfg_smi_en_i = 1'b0;
        @(negedge clk); apm_wr_i = 1'b1;
        @(negedge clk); apm_wr_i = 1'b0;
        check("R10 smi blocked", {31'b0, smi_o}, 32'h0);

        // R2: relocation needs a commit
        @(negedge clk); cfg_base_i = 16'hC000;
        io_read("R2 uncommitted base", 16'hC004, 32'h0);
        check("R2 uncommitted no hit", {31'b0, io_hit_o}, 32'h0);
        io_read("R2 old base live", 16'hB004, 32'h1);
        commit(16'hC000, 1'b1);
        io_read("R2 new base", 16'hC004, 32'h1);
        io_read("R2 old base gone", 16'hB004, 32'h0);
        commit(16'hC000, 1'b0);
        io_read("R2 disabled window", 16'hC004, 32'h0);
        check("R2 disabled no hit", {31'b0, io_hit_o}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule